// File: doc/BRIEF.md
# Two-Stage Wavelength Lane Reshuffler

This block sits between a parallel data word and a bank of ring resonators that each lock onto whichever wavelength channel lies nearest. Because the ring that serves a given channel can change, the data bits have to be moved electronically. A full any-to-any crossbar would do this, but its cost grows with the square of the lane count. This block splits the job into two cheaper stages.

The first stage is a circular rotator. It absorbs the offset that every ring in a bank shares, for example when the whole die warms up. The second stage is a row of small three-input multiplexers, one per lane. It fixes local swaps caused by ring-to-ring mismatch, and each lane can reach only itself or one immediate neighbour.

A controller writes a new rotation amount and a set of lane select codes into shadow registers. A single update strobe then moves all of them into the active mapping at once. The reordered word appears one cycle after the input, with a valid flag alongside it. The block applies the mapping it is given and does not search for one.

Top module: `wdm_bit_reshuffler`

## Requirements
- R1: After reset, out_valid and out_data are 0, and the active mapping is the identity: rotation 0 and every lane select 00.
- R2: Stage one rotates the word circularly. Rotated lane i equals in_data[(i + shift) mod LANES], with shift taking any value from 0 to LANES-1. With every select at 00, out_data is the rotated word.
- R3: Stage two gives output lane i one 2-bit code, held in select bits [2i+1:2i]. The codes mean: 00 or 11 takes rotated lane i, 01 takes rotated lane (i-1) mod LANES, and 10 takes rotated lane (i+1) mod LANES. Lane 0 and lane LANES-1 wrap around to each other.
- R4: cfg_load copies cfg_shift and cfg_sel into shadow registers. The shadow contents have no effect on out_data until a cfg_update.
- R5: cfg_update moves the shadow rotation and all the shadow selects into the active mapping at a single clock edge. A word sampled on that same edge uses the old mapping, and the next word uses the new one. Changing only the rotation leaves the active selects as they were.
- R6: When cfg_load and cfg_update are high in the same cycle, the update takes the shadow contents from before that edge. The newly loaded values wait for a later update.
- R7: out_valid equals in_valid delayed by exactly one clock. out_data carries the word that was sampled with it.
- R8: While in_valid is low, out_data keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word is valid |
| in_data | input | LANES | Logical-lane data word |
| cfg_load | input | 1 | Capture cfg_shift and cfg_sel into shadow registers |
| cfg_shift | input | $clog2(LANES) | New rotation amount |
| cfg_sel | input | 2*LANES | New per-lane select codes, lane i at bits [2i+1:2i] |
| cfg_update | input | 1 | Move the shadow mapping into the active mapping |
| out_valid | output | 1 | Output word is valid |
| out_data | output | LANES | Channel-ordered data word |

## Verification
Three things can happen on the same clock edge: a data word passes through, the mapping is updated, and the shadow registers are loaded. The bench drives all three collisions on purpose with directed steps: data together with an update, load together with an update, and all three at once. It also mixes them at random across a long run. Every word is judged against a bench model that keeps its own shadow and active mapping. That model applies the update before the load and applies the pre-edge mapping to the word, and it builds the full lane permutation as a lookup table.

// File: rtl/reshuffle_pkg.sv
package reshuffle_pkg;

    // Per-lane select code of the local multiplexer stage
    typedef enum logic [1:0] {
        SEL_SELF     = 2'b00,
        SEL_LEFT     = 2'b01,
        SEL_RIGHT    = 2'b10,
        SEL_SELF_ALT = 2'b11
    } lane_sel_e;

endpackage

// File: rtl/reshuffle_cfg.sv
module reshuffle_cfg #(
    parameter int LANES   = 8,
    parameter int SHIFT_W = $clog2(LANES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_load,
    input  logic [SHIFT_W-1:0]   cfg_shift,
    input  logic [2*LANES-1:0]   cfg_sel,
    input  logic                 cfg_update,
    output logic [SHIFT_W-1:0]   act_shift,
    output logic [2*LANES-1:0]   act_sel
);

    typedef struct packed {
        logic [SHIFT_W-1:0] shift;
        logic [2*LANES-1:0] sel;
    } map_t;

    typedef struct packed {
        map_t shadow;
        map_t active;
    } cfg_state_t;

    cfg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        // The update reads the shadow as it stood before this edge
        if (cfg_update) begin
            state_d.active = state_q.shadow;
        end
        if (cfg_load) begin
            state_d.shadow.shift = cfg_shift;
            state_d.shadow.sel   = cfg_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign act_shift = state_q.active.shift;
    assign act_sel   = state_q.active.sel;

    // R6: an update installs the shadow held before the edge, not a simultaneous load
    assert_update_takes_old_shadow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_update && cfg_load) |=> (act_shift == $past(state_q.shadow.shift)
                                      && act_sel == $past(state_q.shadow.sel)));

    // R4: without an update the active mapping never moves
    assert_active_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_update |=> ($stable(act_shift) && $stable(act_sel)));

endmodule

// File: rtl/reshuffle_rotator.sv
module reshuffle_rotator #(
    parameter int LANES   = 8,
    parameter int SHIFT_W = $clog2(LANES)
) (
    input  logic [LANES-1:0]   word_in,
    input  logic [SHIFT_W-1:0] amount,
    output logic [LANES-1:0]   word_out
);

    logic [SHIFT_W:0][LANES-1:0] stage_w;

    assign stage_w[0] = word_in;

    // Stage k rotates by 2**k toward lane 0 when amount bit k is set
    for (genvar k = 0; k < SHIFT_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage_w[k+1] = amount[k]
            ? {stage_w[k][STEP-1:0], stage_w[k][LANES-1:STEP]}
            : stage_w[k];
    end

    assign word_out = stage_w[SHIFT_W];

endmodule

// File: rtl/reshuffle_local_mux.sv
module reshuffle_local_mux
    import reshuffle_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic [LANES-1:0]   word_in,
    input  logic [2*LANES-1:0] sel,
    output logic [LANES-1:0]   word_out
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int LEFT  = (i + LANES - 1) % LANES;
        localparam int RIGHT = (i + 1) % LANES;
        logic pick;

        always_comb begin
            case (lane_sel_e'(sel[2*i +: 2]))
                SEL_LEFT:  pick = word_in[LEFT];
                SEL_RIGHT: pick = word_in[RIGHT];
                default:   pick = word_in[i];
            endcase
        end

        assign word_out[i] = pick;
    end

endmodule

// File: rtl/wdm_bit_reshuffler.sv
module wdm_bit_reshuffler
    import reshuffle_pkg::*;
#(
    parameter int LANES   = 8,
    parameter int SHIFT_W = $clog2(LANES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [LANES-1:0]     in_data,
    input  logic                 cfg_load,
    input  logic [SHIFT_W-1:0]   cfg_shift,
    input  logic [2*LANES-1:0]   cfg_sel,
    input  logic                 cfg_update,
    output logic                 out_valid,
    output logic [LANES-1:0]     out_data
);

    typedef struct packed {
        logic             valid;
        logic [LANES-1:0] data;
    } out_state_t;

    logic [SHIFT_W-1:0] act_shift;
    logic [2*LANES-1:0] act_sel;
    logic [LANES-1:0]   rot_word;
    logic [LANES-1:0]   mixed_word;
    logic               all_self;
    out_state_t         state_d, state_q;

    reshuffle_cfg #(.LANES(LANES), .SHIFT_W(SHIFT_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (cfg_load),
        .cfg_shift  (cfg_shift),
        .cfg_sel    (cfg_sel),
        .cfg_update (cfg_update),
        .act_shift  (act_shift),
        .act_sel    (act_sel)
    );

    reshuffle_rotator #(.LANES(LANES), .SHIFT_W(SHIFT_W)) u_rot (
        .word_in  (in_data),
        .amount   (act_shift),
        .word_out (rot_word)
    );

    reshuffle_local_mux #(.LANES(LANES)) u_mux (
        .word_in  (rot_word),
        .sel      (act_sel),
        .word_out (mixed_word)
    );

    always_comb begin
        all_self = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            if (act_sel[2*i +: 2] == SEL_LEFT || act_sel[2*i +: 2] == SEL_RIGHT) begin
                all_self = 1'b0;
            end
        end
    end

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.data = mixed_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.valid;
    assign out_data  = state_q.data;

    // R7: valid is carried with exactly one cycle of delay
    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_invalid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8: idle cycles leave the output word untouched
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    // R2: the rotator only moves bits, never creates or drops them
    assert_rotate_weight_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rot_word) == $countones(in_data));

    // R2: with every lane on its own position the whole path keeps the weight
    assert_self_path_weight_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && all_self) |=> ($countones(out_data) == $past($countones(in_data))));

endmodule

// File: tb/wdm_bit_reshuffler_test.sv
module wdm_bit_reshuffler_test;

    localparam int N  = 8;
    localparam int SW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [N-1:0]  in_data = '0;
    logic          cfg_load = 1'b0;
    logic [SW-1:0] cfg_shift = '0;
    logic [2*N-1:0] cfg_sel = '0;
    logic          cfg_update = 1'b0;
    logic          out_valid;
    logic [N-1:0]  out_data;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // bench-side model of mapping and output
    logic [SW-1:0]  m_sh_shift = '0;
    logic [2*N-1:0] m_sh_sel   = '0;
    logic [SW-1:0]  m_act_shift = '0;
    logic [2*N-1:0] m_act_sel   = '0;
    logic [N-1:0]   exp_data  = '0;
    logic           exp_valid = 1'b0;

    always #2.5 clk = ~clk;

    wdm_bit_reshuffler #(.LANES(N)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .cfg_load(cfg_load), .cfg_shift(cfg_shift), .cfg_sel(cfg_sel),
        .cfg_update(cfg_update), .out_valid(out_valid), .out_data(out_data)
    );

    // Builds the lane permutation as a lookup table, then applies it
    function automatic logic [N-1:0] ref_map(input logic [N-1:0] d,
                                             input logic [SW-1:0] sh,
                                             input logic [2*N-1:0] sl);
        int src [N];
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            int j;
            case (sl[2*i +: 2])
                2'b01:   j = (i + N - 1) % N;
                2'b10:   j = (i + 1) % N;
                default: j = i;
            endcase
            src[i] = (j + int'(sh)) % N;
        end
        for (int i = 0; i < N; i++) r[i] = d[src[i]];
        return r;
    endfunction

    task automatic check(input string tag);
        tests++;
        if (out_valid !== exp_valid || out_data !== exp_data) begin
            fails++;
            $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
                     tag, out_valid, out_data, exp_valid, exp_data);
        end
    endtask

    // Called just after a falling edge; checks half a cycle after the rising edge
    task automatic step(input logic v, input logic [N-1:0] d,
                        input logic ld, input logic [SW-1:0] sh,
                        input logic [2*N-1:0] sl, input logic upd,
                        input string tag, input bit do_check);
        in_valid = v; in_data = d; cfg_load = ld; cfg_shift = sh;
        cfg_sel = sl; cfg_update = upd;
        @(posedge clk);
        exp_valid = v;
        if (v) exp_data = ref_map(d, m_act_shift, m_act_sel);
        if (upd) begin m_act_shift = m_sh_shift; m_act_sel = m_sh_sel; end
        if (ld)  begin m_sh_shift = sh; m_sh_sel = sl; end
        @(negedge clk);
        if (do_check) check(tag);
    endtask

    task automatic set_map(input logic [SW-1:0] sh, input logic [2*N-1:0] sl);
        step(1'b0, '0, 1'b1, sh, sl, 1'b0, "cfg", 1'b0);
        step(1'b0, '0, 1'b0, '0, '0, 1'b1, "cfg", 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: valid=%0b data=%h expected run to complete", out_valid, out_data);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [2*N-1:0] sl;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset outputs");
        rst_n = 1'b1;
        @(negedge clk);
        // R1: identity mapping straight after reset
        step(1'b1, 8'hA5, 1'b0, '0, '0, 1'b0, "R1 identity after reset", 1'b1);

        // R2: walking one through every rotation amount
        for (int s = 0; s < N; s++) begin
            set_map(SW'(s), '0);
            step(1'b1, 8'h01, 1'b0, '0, '0, 1'b0, "R2 walking one", 1'b1);
            step(1'b1, 8'hC3, 1'b0, '0, '0, 1'b0, "R2 pattern", 1'b1);
        end

        // R3: wrap-around neighbours at both ends, code 11 acts as self
        sl = '0;
        sl[1:0]         = 2'b01;
        sl[2*N-1 -: 2]  = 2'b10;
        sl[5:4]         = 2'b11;
        set_map('0, sl);
        step(1'b1, 8'h81, 1'b0, '0, '0, 1'b0, "R3 end wrap", 1'b1);
        step(1'b1, 8'h04, 1'b0, '0, '0, 1'b0, "R3 code 11", 1'b1);
        set_map(SW'(3), 16'h2486);
        step(1'b1, 8'h5E, 1'b0, '0, '0, 1'b0, "R3 with rotation", 1'b1);

        // R4: load without update leaves mapping alone
        step(1'b1, 8'h3C, 1'b1, SW'(5), 16'h9999, 1'b0, "R4 load only", 1'b1);
        step(1'b1, 8'h71, 1'b0, '0, '0, 1'b0, "R4 after load", 1'b1);

        // R5: update with data on same edge: old, then new mapping
        step(1'b1, 8'h17, 1'b0, '0, '0, 1'b1, "R5 word on update edge", 1'b1);
        step(1'b1, 8'h17, 1'b0, '0, '0, 1'b0, "R5 word after update", 1'b1);
        // R5: drift changes only the rotation, selects kept
        step(1'b0, '0, 1'b1, SW'(6), 16'h9999, 1'b0, "R5 drift", 1'b0);
        step(1'b1, 8'hB2, 1'b0, '0, '0, 1'b1, "R5 drift edge", 1'b1);
        step(1'b1, 8'hB2, 1'b0, '0, '0, 1'b0, "R5 drift applied", 1'b1);

        // R6: load and update together, plus data
        step(1'b1, 8'h4D, 1'b1, SW'(2), 16'h6A51, 1'b1, "R6 load+update+data", 1'b1);
        step(1'b1, 8'h4D, 1'b0, '0, '0, 1'b0, "R6 old shadow applied", 1'b1);
        step(1'b1, 8'h4D, 1'b0, '0, '0, 1'b1, "R6 second update", 1'b1);
        step(1'b1, 8'h4D, 1'b0, '0, '0, 1'b0, "R6 new values applied", 1'b1);

        // R7, R8: idle cycles drop valid and hold data
        step(1'b0, 8'hFF, 1'b0, '0, '0, 1'b0, "R7 valid low", 1'b1);
        step(1'b0, 8'h00, 1'b0, '0, '0, 1'b0, "R8 data held", 1'b1);
        step(1'b1, 8'h96, 1'b0, '0, '0, 1'b0, "R7 valid again", 1'b1);

        // R2_R3_R6 random mix of data, loads and updates
        for (int k = 0; k < 3000; k++) begin
            step(1'($urandom_range(0, 3) != 0), N'($urandom),
                 1'($urandom_range(0, 4) == 0), SW'($urandom), (2*N)'($urandom),
                 1'($urandom_range(0, 5) == 0), "R2_R3_R6 random", 1'b1);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule